// File: doc/BRIEF.md
# Slave Serial Audio Port with Three Framing Formats

This block moves stereo PCM samples between a parallel sample interface and a single-wire serial stream in both directions. The far end owns all timing: the bit clock and the word-select line arrive as inputs, and the block runs on a system clock that is frequency-locked to them. The system clock runs at 256, 384 or 512 times the sample rate, and each channel half of a frame is 32 bit-clock periods long, so one bit period lasts 4, 6 or 8 system clocks.

Both channels share the one data line in each direction, one after the other. The port can frame each word three ways: delayed one bit after the word-select edge, starting on that edge, or ending on the last bit before the next edge. The word length is 16, 18 or 20 bits. Received words appear left-aligned in 20-bit parallel registers, each marked by a one-cycle strobe. Words to transmit are written into per-channel holding registers. The block picks each word up when its half-frame begins.

Top module: `ser_audio_port`

## Requirements
- R1: While reset is low and directly after it, `sd_o` is low, both receive strobes are low and both receive words are zero.
- R2: Format code 00 (and 11, which acts the same) sets delayed framing. The MSB sits in the second bit slot after a word-select change, and word select low marks the left channel.
- R3: Format code 01 sets edge-aligned framing. The MSB sits in the first bit slot after a word-select change, and word select high marks the left channel.
- R4: Format code 10 sets end-aligned framing. The LSB sits in slot 31, the last slot of the 32-slot half, so the MSB sits in slot 32 minus the word length. Word select high marks the left channel.
- R5: The word-length code selects 16 bits (00), 18 bits (01) or 20 bits (10 and 11). A received word is placed at bits 19 downward of `rx_left`/`rx_right`, and the bits below it read zero.
- R6: The transmit line carries the selected channel word in the same slots that the current format uses for receive, MSB first. Every other slot is driven low. This holds from the second full frame after lock.
- R7: A pulse on `tx_left_valid`/`tx_right_valid` writes the channel holding register. The word sent in a half-frame is the one held when the slot before that half is sampled. A write during a half changes only that channel's later halves.
- R8: Ratio code 00, 01 or 10 (11 acts as 10) marks the system clock as 256, 384 or 512 times the sample rate. Each transmit bit changes about half a bit period after the bit-clock rising edge, and the port works at every ratio.
- R9: Nothing is received and `sd_o` stays low until the first word-select change after reset has been seen on a bit-clock rising edge.
- R10: Each receive strobe is high for exactly one system clock per received word, and the left and right strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, locked to the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_sel | input | 2 | System clock to sample rate ratio code |
| fmt_sel | input | 2 | Framing format code |
| wlen_sel | input | 2 | Word length code |
| bclk_i | input | 1 | Serial bit clock from the far end |
| ws_i | input | 1 | Word select from the far end |
| sd_i | input | 1 | Serial receive data |
| sd_o | output | 1 | Serial transmit data |
| tx_left | input | 20 | Left word to transmit |
| tx_left_valid | input | 1 | Write strobe for the left holding register |
| tx_right | input | 20 | Right word to transmit |
| tx_right_valid | input | 1 | Write strobe for the right holding register |
| rx_left | output | 20 | Last received left word, left-aligned |
| rx_left_valid | output | 1 | One-cycle strobe for a new left word |
| rx_right | output | 20 | Last received right word, left-aligned |
| rx_right_valid | output | 1 | One-cycle strobe for a new right word |

## Verification
In end-aligned framing the receive side finishes its word on slot 31. The transmit side loads the other channel's word on that same bit-clock edge, because it looks one slot ahead. Sessions in end-aligned mode at two ratios force these two events onto one system-clock cycle. A receive scoreboard, fed in order by the serial driver, then judges each finished word, and a slot-by-slot compare of the transmit line judges each loaded word. A holding-register write placed right after a half-frame's load adds a third event near that cycle. The transmit compare shows whether the word in flight kept its old value.

// File: rtl/sap_pkg.sv
// Shared codes and helpers for the serial audio port.
// Assumes 32 bit slots per channel half-frame and word lengths of 20 bits or less.
package sap_pkg;

    typedef enum logic [1:0] {
        FMT_DELAYED = 2'b00,
        FMT_EDGE    = 2'b01,
        FMT_END     = 2'b10,
        FMT_ALT     = 2'b11
    } fmt_e;

    // Word length in bits for a length code.
    function automatic int wlen_of(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 18;
            default: return 20;
        endcase
    endfunction

    // Slot that holds the MSB, counted from the word-select change.
    function automatic int first_slot(input logic [1:0] fmt, input int wl, input int slots);
        if (fmt == FMT_EDGE)
            return 0;
        else if (fmt == FMT_END)
            return slots - wl;
        else
            return 1;
    endfunction

    // Extra system clocks between a detected rising edge and the transmit launch.
    // This puts the launch near mid-bit once the two-stage sync latency is counted.
    function automatic int launch_wait(input logic [1:0] ratio);
        int per_bit;
        per_bit = (ratio == 2'b00) ? 4 : (ratio == 2'b01) ? 6 : 8;
        return per_bit / 2 - 2;
    endfunction

    // True when this word-select level marks the left channel.
    function automatic logic is_left(input logic [1:0] fmt, input logic ws);
        return (fmt == FMT_EDGE || fmt == FMT_END) ? ws : ~ws;
    endfunction

endpackage

// File: rtl/sap_pin_sync.sv
// Brings the bit clock, word select and serial data into the system clock domain.
// Emits a one-cycle pulse per bit-clock rising edge, together with word select and
// data sampled in the same stage. Assumes each bit-clock level lasts two system clocks or more.
module sap_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic rise,
    output logic ws_s,
    output logic sd_s
);
    localparam int LANES = 2;

    logic [STAGES:0]   bclk_p;
    logic [LANES-1:0]  lane_in;
    logic [STAGES-1:0] lane_p [LANES];

    assign lane_in = {sd_i, ws_i};

    // Bit clock pipeline, one stage longer so its edge can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_p <= '0;
        else        bclk_p <= {bclk_p[STAGES-1:0], bclk_i};
    end

    // Data lanes, each as deep as the bit clock sync stages.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) lane_p[g] <= '0;
            else        lane_p[g] <= {lane_p[g][STAGES-2:0], lane_in[g]};
        end
    end

    assign rise = bclk_p[STAGES-1] & ~bclk_p[STAGES];
    assign ws_s = lane_p[0][STAGES-1];
    assign sd_s = lane_p[1][STAGES-1];
endmodule

// File: rtl/sap_slot_track.sv
// Follows the position inside each half-frame from word-select changes seen at bit-clock
// rising edges. Gives the next-state slot, channel and lock flag, which are valid in the
// cycle of the edge, so that receive and transmit act on that same edge.
// Assumes the far end holds word select steady for a whole half-frame.
module sap_slot_track import sap_pkg::*; #(
    parameter int SLOTS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rise,
    input  logic                       ws_s,
    input  logic [1:0]                 fmt,
    output logic [$clog2(SLOTS)-1:0]   slot_n,
    output logic                       left_n,
    output logic                       locked_n,
    output logic                       locked
);
    localparam int SW = $clog2(SLOTS);

    logic [SW-1:0] slot_q;
    logic          left_q, primed_q, primed_n, ws_last_q, ws_last_n;

    // Next-state logic: prime on the first edge, restart on a word-select change, else count.
    always_comb begin
        slot_n    = slot_q;
        left_n    = left_q;
        locked_n  = locked;
        primed_n  = primed_q;
        ws_last_n = ws_last_q;
        if (rise) begin
            ws_last_n = ws_s;
            if (!primed_q) begin
                primed_n = 1'b1;
            end else if (ws_s != ws_last_q) begin
                slot_n   = '0;
                left_n   = is_left(fmt, ws_s);
                locked_n = 1'b1;
            end else if (slot_q != SW'(SLOTS - 1)) begin
                slot_n = slot_q + SW'(1);
            end
        end
    end

    // Position registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q    <= '0;
            left_q    <= 1'b0;
            locked    <= 1'b0;
            primed_q  <= 1'b0;
            ws_last_q <= 1'b0;
        end else begin
            slot_q    <= slot_n;
            left_q    <= left_n;
            locked    <= locked_n;
            primed_q  <= primed_n;
            ws_last_q <= ws_last_n;
        end
    end
endmodule

// File: rtl/sap_rx_deser.sv
// Collects the bits of each channel word from the slot position and the framing rules.
// Presents the word left-aligned, with zero fill below it, and a one-cycle strobe for its channel.
// Assumes the format and length codes stay fixed while the port is in use.
module sap_rx_deser import sap_pkg::*; #(
    parameter int MAXW  = 20,
    parameter int SLOTS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rise,
    input  logic [$clog2(SLOTS)-1:0] slot_n,
    input  logic                     left_n,
    input  logic                     locked_n,
    input  logic                     sd_s,
    input  logic [1:0]               fmt,
    input  logic [1:0]               wlen,
    output logic [MAXW-1:0]          rx_left,
    output logic                     rx_left_valid,
    output logic [MAXW-1:0]          rx_right,
    output logic                     rx_right_valid
);
    localparam int SW = $clog2(SLOTS);

    logic [MAXW-1:0] acc_q, acc_d;
    logic            done;
    int              wl, st, d;

    // Place the incoming bit at its weight; clear on the MSB and mark the LSB.
    always_comb begin
        wl    = wlen_of(wlen);
        st    = first_slot(fmt, wl, SLOTS);
        d     = int'(slot_n) - st;
        acc_d = acc_q;
        done  = 1'b0;
        if (rise && locked_n && d >= 0 && d < wl) begin
            if (d == 0) acc_d = '0;
            acc_d = acc_d | ({{(MAXW-1){1'b0}}, sd_s} << (MAXW - 1 - d));
            done  = (d == wl - 1);
        end
    end

    // Accumulator and the per-channel output registers with their strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q          <= '0;
            rx_left        <= '0;
            rx_right       <= '0;
            rx_left_valid  <= 1'b0;
            rx_right_valid <= 1'b0;
        end else begin
            acc_q          <= acc_d;
            rx_left_valid  <= done & left_n;
            rx_right_valid <= done & ~left_n;
            if (done && left_n)  rx_left  <= acc_d;
            if (done && !left_n) rx_right <= acc_d;
        end
    end

    // R10
    rx_pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_left_valid && rx_right_valid));

    // R10
    rx_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_left_valid || rx_right_valid) |=> !(rx_left_valid || rx_right_valid));

    // R4
    rx_end_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_left_valid || rx_right_valid) && fmt == FMT_END) |-> $past(slot_n) == SW'(SLOTS - 1));

    // R3
    rx_edge_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_left_valid || rx_right_valid) && fmt == FMT_EDGE) |-> $past(slot_n) == SW'(wlen_of(wlen) - 1));

    // R2
    rx_delay_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_left_valid || rx_right_valid) && (fmt == FMT_DELAYED || fmt == FMT_ALT))
            |-> $past(slot_n) == SW'(wlen_of(wlen)));
endmodule

// File: rtl/sap_tx_ser.sv
// Serializes the held channel words. On each detected rising edge it works out the bit for
// the next slot: it loads a new word when a half-frame is about to start, and gives zero
// outside the data slots. The bit is driven after a wait set by the clock ratio, which puts
// the change near mid-bit. Assumes the half-frame length stays fixed once locked.
module sap_tx_ser import sap_pkg::*; #(
    parameter int MAXW  = 20,
    parameter int SLOTS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rise,
    input  logic [$clog2(SLOTS)-1:0] slot_n,
    input  logic                     left_n,
    input  logic                     locked_n,
    input  logic [1:0]               fmt,
    input  logic [1:0]               wlen,
    input  logic [1:0]               ratio,
    input  logic [MAXW-1:0]          tx_left,
    input  logic                     tx_left_valid,
    input  logic [MAXW-1:0]          tx_right,
    input  logic                     tx_right_valid,
    output logic                     sd_o
);
    localparam int SW = $clog2(SLOTS);

    logic [MAXW-1:0] hold_l, hold_r, word_q, src, shifted;
    logic [SW-1:0]   p_slot;
    logic            last, p_left, p_bit, pend_q;
    logic [1:0]      dly, wait_q;
    int              wl, st, d;

    // Predict the next slot and work out the bit it carries.
    always_comb begin
        last    = (slot_n == SW'(SLOTS - 1));
        p_slot  = last ? '0 : slot_n + SW'(1);
        p_left  = last ? ~left_n : left_n;
        src     = (p_slot == '0) ? (p_left ? hold_l : hold_r) : word_q;
        wl      = wlen_of(wlen);
        st      = first_slot(fmt, wl, SLOTS);
        d       = int'(p_slot) - st;
        dly     = 2'(launch_wait(ratio));
        shifted = '0;
        p_bit   = 1'b0;
        if (locked_n && d >= 0 && d < wl) begin
            shifted = src << d;
            p_bit   = shifted[MAXW-1];
        end
    end

    // Left holding register, written by its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)             hold_l <= '0;
        else if (tx_left_valid) hold_l <= tx_left;
    end

    // Right holding register, written by its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold_r <= '0;
        else if (tx_right_valid) hold_r <= tx_right;
    end

    // Word in flight, pending bit and delayed launch onto the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            pend_q <= 1'b0;
            wait_q <= '0;
            sd_o   <= 1'b0;
        end else if (rise) begin
            if (locked_n && p_slot == '0) word_q <= src;
            pend_q <= p_bit;
            if (dly == 2'd0) sd_o   <= p_bit;
            else             wait_q <= dly;
        end else if (wait_q != 2'd0) begin
            wait_q <= wait_q - 2'd1;
            if (wait_q == 2'd1) sd_o <= pend_q;
        end
    end

    // R8
    tx_wait_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q <= 2'd2);
endmodule

// File: rtl/ser_audio_port.sv
// Top of the slave serial audio port: pin sync, slot tracking, receive and transmit paths.
// Assumes a system clock locked at 256, 384 or 512 times the sample rate, with 32 bit
// slots per channel half-frame.
module ser_audio_port import sap_pkg::*; #(
    parameter int MAXW   = 20,
    parameter int SLOTS  = 32,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      ratio_sel,
    input  logic [1:0]      fmt_sel,
    input  logic [1:0]      wlen_sel,
    input  logic            bclk_i,
    input  logic            ws_i,
    input  logic            sd_i,
    output logic            sd_o,
    input  logic [MAXW-1:0] tx_left,
    input  logic            tx_left_valid,
    input  logic [MAXW-1:0] tx_right,
    input  logic            tx_right_valid,
    output logic [MAXW-1:0] rx_left,
    output logic            rx_left_valid,
    output logic [MAXW-1:0] rx_right,
    output logic            rx_right_valid
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic              rise, ws_s, sd_s;
    logic [SLOT_W-1:0] slot_n;
    logic              left_n, locked_n, locked;

    sap_pin_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .ws_i(ws_i), .sd_i(sd_i),
        .rise(rise), .ws_s(ws_s), .sd_s(sd_s)
    );

    sap_slot_track #(.SLOTS(SLOTS)) u_track (
        .clk(clk), .rst_n(rst_n), .rise(rise), .ws_s(ws_s), .fmt(fmt_sel),
        .slot_n(slot_n), .left_n(left_n), .locked_n(locked_n), .locked(locked)
    );

    sap_rx_deser #(.MAXW(MAXW), .SLOTS(SLOTS)) u_rx (
        .clk(clk), .rst_n(rst_n), .rise(rise), .slot_n(slot_n), .left_n(left_n),
        .locked_n(locked_n), .sd_s(sd_s), .fmt(fmt_sel), .wlen(wlen_sel),
        .rx_left(rx_left), .rx_left_valid(rx_left_valid),
        .rx_right(rx_right), .rx_right_valid(rx_right_valid)
    );

    sap_tx_ser #(.MAXW(MAXW), .SLOTS(SLOTS)) u_tx (
        .clk(clk), .rst_n(rst_n), .rise(rise), .slot_n(slot_n), .left_n(left_n),
        .locked_n(locked_n), .fmt(fmt_sel), .wlen(wlen_sel), .ratio(ratio_sel),
        .tx_left(tx_left), .tx_left_valid(tx_left_valid),
        .tx_right(tx_right), .tx_right_valid(tx_right_valid), .sd_o(sd_o)
    );

    // R9
    idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !sd_o);

    // R9
    idle_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !(rx_left_valid || rx_right_valid));
endmodule

// File: tb/ser_audio_port_tb_top.sv
// Scoreboard bench: the serial driver queues the expected receive words, a monitor pops and
// compares them, and the transmit line is compared slot by slot within each half-frame.
module ser_audio_port_tb_top;
    localparam int SLOTS = 32;
    localparam int MAXW  = 20;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n = 1'b0;
    logic [1:0]      ratio_sel = '0, fmt_sel = '0, wlen_sel = '0;
    logic            bclk_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
    logic            sd_o;
    logic [MAXW-1:0] tx_left = '0, tx_right = '0;
    logic            tx_left_valid = 1'b0, tx_right_valid = 1'b0;
    logic [MAXW-1:0] rx_left, rx_right;
    logic            rx_left_valid, rx_right_valid;

    int    n_cmp = 0, n_bad = 0;
    bit    finished = 1'b0;
    int    cur_fmt = 0, cur_wl = 20, hp = 2;
    string cur_tag = "";
    logic [MAXW-1:0] q_l[$], q_r[$];

    ser_audio_port #(.MAXW(MAXW), .SLOTS(SLOTS)) dut_i (
        .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .fmt_sel(fmt_sel),
        .wlen_sel(wlen_sel), .bclk_i(bclk_i), .ws_i(ws_i), .sd_i(sd_i), .sd_o(sd_o),
        .tx_left(tx_left), .tx_left_valid(tx_left_valid),
        .tx_right(tx_right), .tx_right_valid(tx_right_valid),
        .rx_left(rx_left), .rx_left_valid(rx_left_valid),
        .rx_right(rx_right), .rx_right_valid(rx_right_valid)
    );

    function automatic int wl_of(input int code);
        return (code == 0) ? 16 : (code == 1) ? 18 : 20;
    endfunction

    function automatic int start_of(input int fmt, input int wl);
        return (fmt == 1) ? 0 : (fmt == 2) ? SLOTS - wl : 1;
    endfunction

    function automatic logic [MAXW-1:0] keep_top(input logic [MAXW-1:0] w, input int wl);
        logic [MAXW-1:0] m;
        m = {MAXW{1'b1}} << (MAXW - wl);
        return w & m;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops an expected word for every receive strobe (R10 exclusivity too).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rx_left_valid && rx_right_valid)
                check(1'b0, "R10 both strobes", 32'(rx_left), 32'(rx_right));
            if (rx_left_valid) begin
                if (q_l.size() == 0) check(1'b0, "R9 unexpected left word", 32'(rx_left), 32'h0);
                else begin
                    logic [MAXW-1:0] e;
                    e = q_l.pop_front();
                    check(rx_left == e, {cur_tag, " left rx"}, 32'(rx_left), 32'(e));
                end
            end
            if (rx_right_valid) begin
                if (q_r.size() == 0) check(1'b0, "R9 unexpected right word", 32'(rx_right), 32'h0);
                else begin
                    logic [MAXW-1:0] e;
                    e = q_r.pop_front();
                    check(rx_right == e, {cur_tag, " right rx"}, 32'(rx_right), 32'(e));
                end
            end
        end
    end

    // Drives one 32-slot half-frame and records the transmit line at every rising edge.
    task automatic send_half(input bit wsv, input bit to_left, input logic [MAXW-1:0] word,
                             input bit push, input bit chk_tx, input logic [MAXW-1:0] txw);
        logic [SLOTS-1:0] cap, expv;
        int st;
        st = start_of(cur_fmt, cur_wl);
        if (push) begin
            if (to_left) q_l.push_back(keep_top(word, cur_wl));
            else         q_r.push_back(keep_top(word, cur_wl));
        end
        for (int s = 0; s < SLOTS; s++) begin
            int d;
            d = s - st;
            bclk_i = 1'b0;
            ws_i   = wsv;
            sd_i   = (d >= 0 && d < cur_wl) ? word[MAXW-1-d] : 1'b0;
            expv[SLOTS-1-s] = (d >= 0 && d < cur_wl) ? txw[MAXW-1-d] : 1'b0;
            repeat (hp) @(negedge clk);
            cap[SLOTS-1-s] = sd_o;
            bclk_i = 1'b1;
            repeat (hp) @(negedge clk);
        end
        if (chk_tx) check(cap == expv, {cur_tag, " R6 R7 tx slots"}, 32'(cap), 32'(expv));
    endtask

    task automatic run_session(input logic [1:0] rc, input logic [1:0] fc, input logic [1:0] wc,
                               input string tag);
        bit ws_r;
        logic [MAXW-1:0] a, b, a2, b2, cur_a, cur_b, lw, rw;
        cur_fmt = int'(fc);
        cur_wl  = wl_of(int'(wc));
        hp      = (rc == 2'b00) ? 2 : (rc == 2'b01) ? 3 : 4;
        cur_tag = tag;
        ws_r    = (fc == 2'b00 || fc == 2'b11);
        rst_n = 1'b0; ratio_sel = rc; fmt_sel = fc; wlen_sel = wc;
        bclk_i = 1'b0; ws_i = ws_r; sd_i = 1'b0;
        repeat (5) @(negedge clk);
        check(sd_o == 1'b0 && !rx_left_valid && !rx_right_valid, "R1 outputs in reset",
              {30'd0, sd_o, rx_left_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_left == '0 && rx_right == '0 && sd_o == 1'b0, "R1 after reset",
              32'(rx_left | rx_right), 32'h0);
        a = 20'($urandom); b = 20'($urandom);
        a2 = ~a; b2 = 20'($urandom);
        tx_left = a; tx_right = b; tx_left_valid = 1'b1; tx_right_valid = 1'b1;
        @(negedge clk);
        tx_left_valid = 1'b0; tx_right_valid = 1'b0;
        cur_a = a; cur_b = b;
        // Idle half before lock: its data must not surface (R9).
        send_half(ws_r, 1'b0, 20'hABCDE, 1'b0, 1'b0, '0);
        check(sd_o == 1'b0, "R9 line low before lock", 32'(sd_o), 32'h0);
        for (int f = 0; f < 4; f++) begin
            lw = (f == 0) ? 20'hFFFFF : (f == 1) ? 20'h80001 : 20'($urandom);
            rw = (f == 0) ? 20'h55555 : (f == 1) ? 20'hFFFFF : 20'($urandom);
            send_half(~ws_r, 1'b1, lw, 1'b1, f >= 1, cur_a);
            if (f == 2) begin
                // The right word is already loaded; new words apply to later halves (R7).
                tx_left = a2; tx_right = b2; tx_left_valid = 1'b1; tx_right_valid = 1'b1;
                @(negedge clk);
                tx_left_valid = 1'b0; tx_right_valid = 1'b0;
                cur_a = a2;
            end
            send_half(ws_r, 1'b0, rw, 1'b1, f >= 1, cur_b);
            if (f == 2) cur_b = b2;
        end
        repeat (16) @(negedge clk);
        check(q_l.size() == 0 && q_r.size() == 0, {tag, " R10 every word strobed once"},
              32'(q_l.size() + q_r.size()), 32'h0);
        q_l.delete();
        q_r.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        run_session(2'b00, 2'b00, 2'b10, "R2 R5 R8 delayed 20b x256");
        run_session(2'b01, 2'b01, 2'b00, "R3 R5 R8 edge 16b x384");
        run_session(2'b10, 2'b10, 2'b01, "R4 R5 R8 end 18b x512");
        run_session(2'b00, 2'b10, 2'b00, "R4 R5 R8 end 16b x256");
        run_session(2'b01, 2'b00, 2'b01, "R2 R5 R8 delayed 18b x384");
        run_session(2'b10, 2'b01, 2'b11, "R3 R5 R8 edge code11 x512");
        run_session(2'b11, 2'b11, 2'b10, "R2 R8 alt codes x512");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule